// File: doc/BRIEF.md
# E3 Receive BIP-8 Parity Monitor

This block watches received E3 frames one byte at a time and checks the interleaved even-parity byte (BIP-8) that every frame carries. For each frame it builds an eight-lane parity byte over all bytes of the frame. In the frame that follows, the parity-carrying byte (marked by the `rx_em_pos` strobe) must equal that value. When the two differ, the error has three effects. The local transmitter is asked to flag one outgoing frame with the far-end block error bit in its maintenance byte. A read-clear interrupt status bit is latched. A 16-bit read-clear parity error counter goes up by one.

A small state machine controls the checking. The states are HUNT, PRIME, FIRST and CHECK. Any state goes to HUNT whenever `frame_aligned` is low. HUNT goes to PRIME on the next cycle with `frame_aligned` high. PRIME goes to FIRST on the next start-of-frame byte. FIRST goes to CHECK on the start-of-frame byte after that. CHECK stays in CHECK. The frame accumulated in FIRST only primes the reference parity. A microprocessor reads the status and counter bytes through a byte-addressed read port, and the data appears one cycle after the read strobe.

Top module: `e3_bip_monitor`

## Requirements
- R1: After reset the status byte at 0x15 and both counter bytes (0x54, 0x55) read 0, `tx_ma_byte` is 0x00 and `irq` is low.
- R2: The parity of a frame is the bitwise XOR of every valid byte from its start-of-frame byte up to the byte before the next start-of-frame. That parity is compared with the byte flagged by `rx_em_pos` in the next frame, which may be the start-of-frame byte itself. Any difference counts as one error.
- R3: No error is counted while `frame_aligned` is low. The first frame that starts after alignment rises, or rises again, only primes the reference, whatever its parity byte holds.
- R4: An error sets bit 2 of the status byte at 0x15, and every other bit of that byte reads 0. A read of 0x15 clears the bit, except when an error arrives in the same cycle as the read; the bit then stays set.
- R5: `irq` is high exactly while the status bit is set and `irq_en` is high.
- R6: Each error adds one to the 16-bit counter, and the counter holds at 0xFFFF.
- R7: A read of 0x54 returns the counter's high byte, copies its low byte into a holding byte that a read of 0x55 returns, and clears the counter. An error in the same cycle as that read leaves the counter at 1.
- R8: `rd_data` shows the addressed byte on the cycle after `rd_en`. Addresses other than 0x15, 0x54 and 0x55 read 0, and `rd_data` is 0 on any cycle that follows no read.
- R9: Bit 6 of `tx_ma_byte` is 1 for exactly one transmit frame per errored receive frame, and all other bits are 0. The byte changes only at a `tx_sof` pulse. Up to 7 owed frames are held; further errors beyond that are dropped.
- R10: An error in the same cycle as `tx_sof` is not sent in the frame starting then. It goes out in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_aligned | input | 1 | Frame alignment has been declared |
| rx_valid | input | 1 | A received byte is present |
| rx_sof | input | 1 | The present byte is the first of a frame |
| rx_em_pos | input | 1 | The present byte is the parity-carrying byte |
| rx_byte | input | 8 | Received byte |
| tx_sof | input | 1 | The local transmitter starts a frame |
| tx_ma_byte | output | 8 | Maintenance byte for the transmitter; bit 6 is the far-end block error bit |
| irq_en | input | 1 | Interrupt enable for the parity status bit |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, one cycle after the strobe |
| irq | output | 1 | Interrupt request |

## Verification
Random frames of varied length are used, with the parity byte at a random position. About a third of them have one parity bit flipped, so the error count must match the flipped frames exactly and cannot be satisfied by counting all frames or none. Frames that are flipped before alignment, and primer frames after alignment is lost and regained, show whether the gating is right. Single-byte frames, where the start and parity bytes coincide, exercise the reference bypass. They also place errors in the same cycle as a status read, a counter read or a transmit frame start, which separates "error wins" from "clear wins". A run of more than 65,535 back-to-back errors shows whether the counter saturates or wraps and whether the owed-frame count stops at 7.

// File: rtl/e3bm_pkg.sv
package e3bm_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_PRIME,
        ST_FIRST,
        ST_CHECK
    } frm_state_t;

    localparam logic [7:0] ADDR_STATUS = 8'h15;
    localparam logic [7:0] ADDR_CNT_HI = 8'h54;
    localparam logic [7:0] ADDR_CNT_LO = 8'h55;

    localparam int BIP_STATUS_BIT = 2;
    localparam int FEBE_MA_BIT    = 6;

endpackage

// File: rtl/e3bm_frame_fsm.sv
module e3bm_frame_fsm
    import e3bm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_aligned,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic          rx_em_pos,
    input  logic [DW-1:0] rx_byte,
    output logic          bip_err
);

    frm_state_t state, state_nxt;
    logic [DW-1:0] acc_par;
    logic [DW-1:0] ref_par;
    logic [DW-1:0] cmp_par;
    logic          sof_byte;
    logic          check_en;

    assign sof_byte = rx_valid && rx_sof;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        if (!frame_aligned) begin
            state_nxt = ST_HUNT;
        end else begin
            unique case (state)
                ST_HUNT:  state_nxt = ST_PRIME;
                ST_PRIME: if (sof_byte) state_nxt = ST_FIRST;
                ST_FIRST: if (sof_byte) state_nxt = ST_CHECK;
                ST_CHECK: state_nxt = ST_CHECK;
            endcase
        end
    end

    // running parity and the reference taken at each frame boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_par <= '0;
            ref_par <= '0;
        end else if (rx_valid && state != ST_HUNT) begin
            if (rx_sof) begin
                ref_par <= acc_par;
                acc_par <= rx_byte;
            end else begin
                acc_par <= acc_par ^ rx_byte;
            end
        end
    end

    // outputs: the parity byte of a frame may sit on its own start byte
    always_comb begin
        cmp_par  = rx_sof ? acc_par : ref_par;
        unique case (state)
            ST_CHECK: check_en = 1'b1;
            ST_FIRST: check_en = rx_sof;
            ST_HUNT,
            ST_PRIME: check_en = 1'b0;
        endcase
        bip_err = frame_aligned && rx_valid && rx_em_pos && check_en
                  && (rx_byte != cmp_par);
    end

endmodule

// File: rtl/e3bm_febe_tx.sv
module e3bm_febe_tx #(
    parameter int PEND_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bip_err,
    input  logic tx_sof,
    output logic febe_active
);

    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    logic [PEND_W-1:0] pend;
    logic [PEND_W-1:0] pend_base;
    logic [PEND_W-1:0] pend_nxt;
    logic              owe;

    always_comb begin
        owe       = (pend != '0);
        pend_base = (tx_sof && owe) ? pend - 1'b1 : pend;
        pend_nxt  = (bip_err && pend_base != PEND_MAX) ? pend_base + 1'b1 : pend_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend        <= '0;
            febe_active <= 1'b0;
        end else begin
            pend <= pend_nxt;
            if (tx_sof) begin
                febe_active <= owe;
            end
        end
    end

endmodule

// File: rtl/e3bm_regs.sv
module e3bm_regs
    import e3bm_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bip_err,
    input  logic            irq_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            irq,
    output logic            st_bip,
    output logic [2*DW-1:0] err_cnt
);

    localparam int CNT_W = 2 * DW;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic            rd_st, rd_hi, rd_lo;
    logic [DW-1:0]   lo_hold;
    logic [DW-1:0]   st_word;
    logic [CNT_W-1:0] cnt_base;

    always_comb begin
        rd_st    = rd_en && (rd_addr == AW'(ADDR_STATUS));
        rd_hi    = rd_en && (rd_addr == AW'(ADDR_CNT_HI));
        rd_lo    = rd_en && (rd_addr == AW'(ADDR_CNT_LO));
        st_word  = '0;
        st_word[BIP_STATUS_BIT] = st_bip;
        cnt_base = rd_hi ? '0 : err_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_bip  <= 1'b0;
            err_cnt <= '0;
            lo_hold <= '0;
            rd_data <= '0;
        end else begin
            if (bip_err) begin
                st_bip <= 1'b1;
            end else if (rd_st) begin
                st_bip <= 1'b0;
            end
            err_cnt <= (bip_err && cnt_base != CNT_MAX) ? cnt_base + 1'b1 : cnt_base;
            if (rd_hi) begin
                lo_hold <= err_cnt[DW-1:0];
            end
            if (rd_st) begin
                rd_data <= st_word;
            end else if (rd_hi) begin
                rd_data <= err_cnt[CNT_W-1:DW];
            end else if (rd_lo) begin
                rd_data <= lo_hold;
            end else begin
                rd_data <= '0;
            end
        end
    end

    assign irq = st_bip && irq_en;

endmodule

// File: rtl/e3_bip_monitor.sv
module e3_bip_monitor
    import e3bm_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 8,
    parameter int PEND_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_aligned,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic          rx_em_pos,
    input  logic [DW-1:0] rx_byte,
    input  logic          tx_sof,
    output logic [DW-1:0] tx_ma_byte,
    input  logic          irq_en,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          irq
);

    logic            bip_err;
    logic            febe_active;
    logic            st_bip;
    logic [2*DW-1:0] err_cnt;

    e3bm_frame_fsm #(.DW(DW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_aligned (frame_aligned),
        .rx_valid      (rx_valid),
        .rx_sof        (rx_sof),
        .rx_em_pos     (rx_em_pos),
        .rx_byte       (rx_byte),
        .bip_err       (bip_err)
    );

    e3bm_febe_tx #(.PEND_W(PEND_W)) u_febe (
        .clk         (clk),
        .rst_n       (rst_n),
        .bip_err     (bip_err),
        .tx_sof      (tx_sof),
        .febe_active (febe_active)
    );

    e3bm_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .bip_err (bip_err),
        .irq_en  (irq_en),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq),
        .st_bip  (st_bip),
        .err_cnt (err_cnt)
    );

    for (genvar i = 0; i < DW; i++) begin : g_ma
        if (i == FEBE_MA_BIT) begin : g_febe
            assign tx_ma_byte[i] = febe_active;
        end else begin : g_zero
            assign tx_ma_byte[i] = 1'b0;
        end
    end

endmodule

// File: rtl/e3bm_checker.sv
module e3bm_checker #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_aligned,
    input logic            tx_sof,
    input logic            rd_en,
    input logic [AW-1:0]   rd_addr,
    input logic [DW-1:0]   rd_data,
    input logic            bip_err,
    input logic            st_bip,
    input logic            febe_active,
    input logic [2*DW-1:0] err_cnt
);

    logic rd_hi_c, rd_known_c;
    assign rd_hi_c    = rd_en && (rd_addr == AW'(8'h54));
    assign rd_known_c = (rd_addr == AW'(8'h15)) || (rd_addr == AW'(8'h54))
                        || (rd_addr == AW'(8'h55));

    assert_no_check_unaligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_aligned |-> !bip_err);

    assert_status_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bip_err |=> st_bip);

    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bip_err && !rd_hi_c && err_cnt != '1) |=> (err_cnt == $past(err_cnt) + 1'b1));

    assert_cnt_holds_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == '1 && !rd_hi_c) |=> (err_cnt == '1));

    assert_hi_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi_c && !bip_err) |=> (err_cnt == '0));

    assert_unknown_addr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || !rd_known_c) |=> (rd_data == '0));

    assert_febe_moves_on_tx_sof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_sof |=> $stable(febe_active));

endmodule

bind e3_bip_monitor e3bm_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_aligned (frame_aligned),
    .tx_sof        (tx_sof),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .bip_err       (bip_err),
    .st_bip        (st_bip),
    .febe_active   (febe_active),
    .err_cnt       (err_cnt)
);

// File: tb/sim_e3_bip_monitor.sv
module sim_e3_bip_monitor;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, frame_aligned = 1'b0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_em_pos = 1'b0, tx_sof = 1'b0;
    logic irq_en = 1'b0, rd_en = 1'b0, irq;
    logic [7:0] rx_byte = '0, rd_addr = '0, rd_data, tx_ma_byte;

    int n_cmp = 0, n_bad = 0;
    int exp_cnt = 0, exp_pend = 0, phase = 0;
    bit exp_st = 1'b0;
    logic [7:0] b_ref = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    e3_bip_monitor u0 (
        .clk(clk), .rst_n(rst_n), .frame_aligned(frame_aligned),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_em_pos(rx_em_pos), .rx_byte(rx_byte),
        .tx_sof(tx_sof), .tx_ma_byte(tx_ma_byte), .irq_en(irq_en),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] flip_mask();
        return 8'h01 << ($urandom % 8);
    endfunction

    task automatic note_err(bit e);
        if (e) begin
            exp_cnt  = (exp_cnt == 65535) ? 65535 : exp_cnt + 1;
            exp_pend = (exp_pend == 7) ? 7 : exp_pend + 1;
            exp_st   = 1'b1;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_em_pos = 0; tx_sof = 0; rd_en = 0;
    endtask

    // one frame; the parity byte copies the reference, optionally with one bit flipped
    task automatic send_frame(int len, int em_idx, bit corrupt);
        logic [7:0] par = '0;
        logic [7:0] b;
        bit checked;
        checked = (phase == 2) && frame_aligned;
        for (int i = 0; i < len; i++) begin
            b = (i == em_idx) ? (b_ref ^ (corrupt ? flip_mask() : 8'h00)) : 8'($urandom);
            @(negedge clk);
            rx_valid = 1; rx_byte = b; rx_sof = (i == 0); rx_em_pos = (i == em_idx);
            par ^= b;
        end
        idle();
        note_err(checked && corrupt);
        b_ref = par;
        if (phase == 1) phase = 2;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1; rd_addr = a;
        @(negedge clk); rd_en = 0; d = rd_data;
    endtask

    task automatic read_status(string req);
        logic [7:0] d;
        rd(8'h15, d);
        chk(req, d, exp_st ? 8'h04 : 8'h00);
        exp_st = 0;
    endtask

    task automatic read_cnt(string req);
        logic [7:0] d;
        int snap;
        rd(8'h54, d);
        chk(req, d, exp_cnt >> 8);
        snap = exp_cnt & 8'hFF;
        exp_cnt = 0;
        rd(8'h55, d);
        chk(req, d, snap);
    endtask

    task automatic tx_pulse(string req);
        @(negedge clk); tx_sof = 1;
        @(negedge clk); tx_sof = 0;
        chk(req, tx_ma_byte, exp_pend > 0 ? 8'h40 : 8'h00);
        if (exp_pend > 0) exp_pend--;
    endtask

    // single-byte frame (start and parity byte coincide) with optional read / tx start
    task automatic one_byte(bit corrupt, bit with_rd, logic [7:0] a, bit with_tx,
                            output logic [7:0] d, output bit act);
        logic [7:0] b;
        b = b_ref ^ (corrupt ? 8'hFF : 8'h00);
        @(negedge clk);
        rx_valid = 1; rx_sof = 1; rx_em_pos = 1; rx_byte = b;
        rd_en = with_rd; rd_addr = a; tx_sof = with_tx;
        act = 0;
        if (with_tx) begin
            act = (exp_pend > 0);
            if (act) exp_pend--;
        end
        idle();
        d = rd_data;
        b_ref = b;
        note_err(corrupt && phase == 2);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        bit act;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        irq_en = 1;
        @(negedge clk);
        chk("R1 ma byte", tx_ma_byte, 0);
        chk("R1 irq", irq, 0);
        read_status("R1 status");
        read_cnt("R1 counter");

        // R3: flipped parity while unaligned
        for (int k = 0; k < 3; k++) send_frame(6, 2, 1);
        read_status("R3 unaligned status");
        read_cnt("R3 unaligned counter");

        // R3/R2: align, primer frame is flipped but ignored, then a clean frame
        @(negedge clk); frame_aligned = 1;
        idle(); idle();
        phase = 1;
        send_frame(8, 3, 1);
        send_frame(8, 3, 0);
        read_status("R3 primer ignored");

        // R2/R4/R5/R7: one error
        send_frame(8, 3, 1);
        @(negedge clk); irq_en = 1;
        @(negedge clk); chk("R5 irq enabled", irq, 1);
        irq_en = 0;
        @(negedge clk); chk("R5 irq masked", irq, 0);
        read_status("R4 status set");
        read_status("R4 status cleared");
        read_cnt("R7 counter one");
        read_cnt("R7 counter cleared by high read");
        rd(8'h20, d); chk("R8 unknown address", d, 0);

        // R9: one owed frame
        tx_pulse("R9 febe sent");
        tx_pulse("R9 febe once");

        // random frames
        for (int k = 0; k < 40; k++) begin
            int len;
            len = 4 + ($urandom % 9);
            irq_en = $urandom % 2;
            send_frame(len, $urandom % len, ($urandom % 3) == 0);
            chk("R5 irq random", irq, exp_st & irq_en);
        end
        read_status("R4 random status");
        read_cnt("R2 random count");
        for (int k = 0; k < 8; k++) tx_pulse("R9 random drain");

        // R3: alignment lost and regained
        @(negedge clk); frame_aligned = 0; phase = 0;
        idle();
        @(negedge clk); frame_aligned = 1;
        idle(); idle();
        phase = 1;
        send_frame(5, 1, 1);
        read_status("R3 realign primer");
        read_cnt("R3 realign counter");

        // R4: error in the cycle of a status read
        one_byte(1, 1, 8'h15, 0, d, act);
        chk("R4 read data before error", d, 0);
        read_status("R4 error beats clear");
        // R7: error in the cycle of a high-byte read
        one_byte(1, 1, 8'h54, 0, d, act);
        chk("R7 high byte before error", d, 0);
        exp_cnt = 1;
        read_cnt("R7 error beats clear");
        read_status("R4 cleanup");
        tx_pulse("R9 drain a");
        tx_pulse("R9 drain b");

        // R10: error on the tx start cycle
        one_byte(1, 0, 8'h00, 1, d, act);
        chk("R10 not in current frame", tx_ma_byte, act ? 8'h40 : 8'h00);
        tx_pulse("R10 next frame");
        tx_pulse("R10 then clear");

        // R6/R9: saturation run
        for (int k = 0; k < 65540; k++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = 1; rx_em_pos = 1; rx_byte = ~b_ref;
            b_ref = ~b_ref;
            note_err(1);
        end
        idle();
        read_cnt("R6 saturated");
        read_status("R4 after run");
        for (int k = 0; k < 8; k++) tx_pulse("R9 owed cap");

        summary();
        $finish;
    end
endmodule